// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out a move-multiple-registers operation for a CPU with sixteen 32-bit registers. Indices 0 to 7 are the data registers and indices 8 to 15 are the address registers. A 16-bit list mask picks which registers take part. The sequencer then moves each chosen register to or from consecutive memory locations, one memory transfer at a time. It talks to memory through a single request/acknowledge port, and it reads and writes the register file through a dedicated port. Instruction decode and effective-address calculation happen upstream. The block is handed a ready effective address, the index of the address register that forms the base, and the operation's direction, size and addressing mode.

Register stores walk the list from the lowest index to the highest with a rising address. Predecrement stores are the exception: they walk from the highest index down, and the mask bits are mirrored. Loads gather every memory value into a private buffer first, and only afterwards update the registers. A register therefore never changes while reads are still in flight. In postincrement and predecrement modes, the block finishes by writing the updated address back into the base register.

Two build-time switches shape the block. The extended-generation switch changes the value stored when a predecrement store lists its own base register. The reduced-instruction-set switch narrows the combinations that are accepted. A rejected combination never touches memory or the register file.

Top module: `regblk_xfer`

## Requirements
- R1: After reset the block is idle: `mem_req_o`, `rf_we_o`, `done_o` and `illegal_o` are all low until a start is accepted.
- R2: `load_i`=1 moves memory to registers and 0 moves registers to memory. `long_i`=1 selects 32-bit transfers with a 4-byte address step, and 0 selects 16-bit transfers with a 2-byte step. `mem_long_o` reports the size. `mode_i` encodes 0 = plain indirect, 1 = postincrement, 2 = predecrement, 3 = displacement (treated like plain indirect).
- R3: Except for predecrement stores, mask bit i selects register i. Registers move in rising index order. The first transfer uses `ea_i`, and each later one uses the previous address plus the step.
- R4: In a predecrement store, mask bit j selects register 15-j. Registers are stored from index 15 down to 0. The address falls by the step between stores but not after the last one. That final address is then written to register 8+`base_i`.
- R5: In a predecrement store whose list holds the base register (8+`base_i`), the value stored for it is its initial value minus the step when `EXT_CPU`=1, and its unmodified initial value when `EXT_CPU`=0.
- R6: A load issues every memory read before any register write. Only after the last read does it write the selected registers, one per cycle, in rising index order.
- R7: A postincrement load then writes the address that follows the last read (`ea_i` + step × count) to register 8+`base_i`. This write comes last, so it wins over a loaded value for the same register. Plain-indirect, displacement and predecrement loads write nothing back.
- R8: A 16-bit load sign-extends bits 15:0 of the read data to 32 bits. A 16-bit store drives the register's bits 15:0 on `mem_wdata_o[15:0]`, with bits 31:16 set to zero.
- R9: A store in postincrement mode is illegal. With `REDUCED_ISA`=1, any 16-bit operation and any postincrement or predecrement operation is also illegal. An illegal start raises `illegal_o` for exactly the next cycle, makes no memory or register access, and leaves the block idle.
- R10: A legal start with an all-zero mask raises `done_o` in the next cycle. It makes no memory request and no register write, so the base register is left unchanged.
- R11: A memory request holds its address, write data, direction and size stable until it is acknowledged. At most one request is outstanding at a time.
- R12: `start_i` is ignored while an operation is in progress.
- R13: `done_o` is high for exactly one cycle. That cycle directly follows the last acknowledged transfer or register write of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| long_i | input | 1 | 1 = 32-bit transfers, 0 = 16-bit transfers |
| mode_i | input | 2 | Addressing mode: 0 indirect, 1 postincrement, 2 predecrement, 3 displacement |
| mask_i | input | 16 | Register list |
| ea_i | input | AW | Address of the first transfer |
| base_i | input | 3 | Index of the base address register (register 8+base_i) |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_long_o | output | 1 | Request is 32-bit (else 16-bit) |
| mem_addr_o | output | AW | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| done_o | output | 1 | Operation finished (one cycle) |
| illegal_o | output | 1 | Start rejected (one cycle) |

## Verification
The transfer is driven with sparse and full masks, lists that hold the base register, both sizes and all four modes, while the memory side acknowledges after zero, one or two wait cycles. Masks split across data and address registers separate the rising walk from the mirrored predecrement walk. Word loads from addresses whose bit 15 alternates separate sign extension from zero extension. Lists that contain the base register separate the step-adjusted stored value and the order of load versus writeback. An empty mask, illegal combinations and a start pulsed mid-operation show that no stray access or state change occurs.

// File: rtl/regblk_pkg.sv
`timescale 1ns/1ps
package regblk_pkg;

    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int BIDX_W = RIDX_W - 1;
    localparam int DATA_W = 32;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        AM_IND     = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MOVE,
        ST_COMMIT,
        ST_WBACK,
        ST_FIN,
        ST_BAD
    } state_e;

    typedef struct packed {
        logic              load;
        logic              lng;
        amode_e            mode;
        logic [BIDX_W-1:0] base;
    } op_t;

    function automatic logic [2:0] step_bytes(logic lng);
        return lng ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [DATA_W-1:0] sext_word(logic [WORD_W-1:0] w);
        return {{(DATA_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

    function automatic logic op_ok(op_t op, logic reduced);
        if (!op.load && op.mode == AM_POSTINC)
            return 1'b0;
        if (reduced && (!op.lng || op.mode == AM_POSTINC || op.mode == AM_PREDEC))
            return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/regblk_pick.sv
`timescale 1ns/1ps
module regblk_pick #(
    parameter int N          = 16,
    parameter bit HIGH_FIRST = 1'b0
) (
    input  logic [N-1:0]         vec_i,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 last_o
);
    localparam int IW = $clog2(N);

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < N; i++)
                    if (vec_i[i]) idx_o = IW'(i);
            end
        end else begin : g_low
            always_comb begin
                idx_o = '0;
                for (int i = N - 1; i >= 0; i--)
                    if (vec_i[i]) idx_o = IW'(i);
            end
        end
    endgenerate

    assign last_o = (|vec_i) && ((vec_i & (vec_i - N'(1))) == '0);

endmodule

// File: rtl/regblk_lbuf.sv
`timescale 1ns/1ps
module regblk_lbuf #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 we_i,
    input  logic [$clog2(N)-1:0] widx_i,
    input  logic [W-1:0]         wdata_i,
    input  logic [$clog2(N)-1:0] ridx_i,
    output logic [W-1:0]         rdata_o
);
    logic [W-1:0] slot_q [N];

    always_ff @(posedge clk) begin
        if (we_i) slot_q[widx_i] <= wdata_i;
    end

    assign rdata_o = slot_q[ridx_i];

endmodule

// File: rtl/regblk_addr.sv
`timescale 1ns/1ps
module regblk_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] init_i,
    input  logic          inc_i,
    input  logic          dec_i,
    input  logic [2:0]    step_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (load_i) addr_q <= init_i;
        else if (inc_i)  addr_q <= addr_q + AW'(step_i);
        else if (dec_i)  addr_q <= addr_q - AW'(step_i);
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/regblk_xfer.sv
`timescale 1ns/1ps
module regblk_xfer
    import regblk_pkg::*;
#(
    parameter int AW          = 32,
    parameter bit EXT_CPU     = 1'b1,
    parameter bit REDUCED_ISA = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              load_i,
    input  logic              long_i,
    input  logic [1:0]        mode_i,
    input  logic [NREG-1:0]   mask_i,
    input  logic [AW-1:0]     ea_i,
    input  logic [BIDX_W-1:0] base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_long_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [RIDX_W-1:0] rf_raddr_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              rf_we_o,
    output logic [RIDX_W-1:0] rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              done_o,
    output logic              illegal_o
);
    state_e            state_q, state_d;
    op_t               op_q, op_in;
    logic [NREG-1:0]   pend_q, cmask_q, mask_rev;
    logic [RIDX_W-1:0] lo_idx, hi_idx, mv_idx, c_idx, base_reg;
    logic              lo_last, hi_last, mv_last, c_last;
    logic              rev, in_rev, accept, mv_fire;
    logic [2:0]        step;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] sv, buf_rd, ld_val;

    assign op_in  = '{load: load_i, lng: long_i, mode: amode_e'(mode_i), base: base_i};
    assign in_rev = !load_i && (amode_e'(mode_i) == AM_PREDEC);
    assign accept = (state_q == ST_IDLE) && start_i;

    // Predecrement lists are mirrored once at start so the walker sees register order
    always_comb begin
        for (int i = 0; i < NREG; i++)
            mask_rev[i] = mask_i[NREG-1-i];
    end

    assign rev      = !op_q.load && (op_q.mode == AM_PREDEC);
    assign step     = step_bytes(op_q.lng);
    assign base_reg = {1'b1, op_q.base};

    regblk_pick #(.N(NREG), .HIGH_FIRST(1'b0)) u_pick_lo (
        .vec_i(pend_q), .idx_o(lo_idx), .last_o(lo_last)
    );
    regblk_pick #(.N(NREG), .HIGH_FIRST(1'b1)) u_pick_hi (
        .vec_i(pend_q), .idx_o(hi_idx), .last_o(hi_last)
    );
    regblk_pick #(.N(NREG), .HIGH_FIRST(1'b0)) u_pick_commit (
        .vec_i(cmask_q), .idx_o(c_idx), .last_o(c_last)
    );

    assign mv_idx  = rev ? hi_idx : lo_idx;
    assign mv_last = rev ? hi_last : lo_last;
    assign mv_fire = (state_q == ST_MOVE) && mem_ack_i;

    regblk_addr #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .init_i (ea_i),
        .inc_i  (mv_fire && !rev),
        .dec_i  (mv_fire && rev && !mv_last),
        .step_i (step),
        .addr_o (addr_q)
    );

    assign ld_val = op_q.lng ? mem_rdata_i : sext_word(mem_rdata_i[WORD_W-1:0]);

    regblk_lbuf #(.N(NREG), .W(DATA_W)) u_lbuf (
        .clk     (clk),
        .we_i    (mv_fire && op_q.load),
        .widx_i  (mv_idx),
        .wdata_i (ld_val),
        .ridx_i  (c_idx),
        .rdata_o (buf_rd)
    );

    // Store data: the base register may be stored pre-adjusted by one step
    always_comb begin
        sv = rf_rdata_i;
        if (EXT_CPU && rev && (mv_idx == base_reg))
            sv = rf_rdata_i - DATA_W'(step);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!op_ok(op_in, REDUCED_ISA)) state_d = ST_BAD;
                    else if (mask_i == '0)          state_d = ST_FIN;
                    else                            state_d = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (mem_ack_i && mv_last)
                    state_d = op_q.load ? ST_COMMIT : (rev ? ST_WBACK : ST_FIN);
            end
            ST_COMMIT: begin
                if (c_last)
                    state_d = (op_q.mode == AM_POSTINC) ? ST_WBACK : ST_FIN;
            end
            ST_WBACK: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            ST_BAD:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            pend_q  <= '0;
            cmask_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q    <= op_in;
                pend_q  <= in_rev ? mask_rev : mask_i;
                cmask_q <= mask_i;
            end
            if (mv_fire)
                pend_q[mv_idx] <= 1'b0;
            if (state_q == ST_COMMIT)
                cmask_q[c_idx] <= 1'b0;
        end
    end

    assign mem_req_o   = (state_q == ST_MOVE);
    assign mem_we_o    = !op_q.load;
    assign mem_long_o  = op_q.lng;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = op_q.lng ? sv : {{(DATA_W-WORD_W){1'b0}}, sv[WORD_W-1:0]};
    assign rf_raddr_o  = mv_idx;
    assign rf_we_o     = (state_q == ST_COMMIT) || (state_q == ST_WBACK);
    assign rf_waddr_o  = (state_q == ST_COMMIT) ? c_idx : base_reg;
    assign rf_wdata_o  = (state_q == ST_COMMIT) ? buf_rd : DATA_W'(addr_q);
    assign done_o      = (state_q == ST_FIN);
    assign illegal_o   = (state_q == ST_BAD);

endmodule

// File: rtl/regblk_xfer_chk.sv
`timescale 1ns/1ps
module regblk_xfer_chk
    import regblk_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_long_o,
    input logic [AW-1:0]     mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ack_i,
    input logic              rf_we_o,
    input logic              done_o,
    input logic              illegal_o
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)
                                    && $stable(mem_we_o) && $stable(mem_long_o)); // R11
    AST_NO_RF_DURING_MEM: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> !rf_we_o); // R6
    AST_WORD_STORE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o && !mem_long_o |-> mem_wdata_o[DATA_W-1:WORD_W] == '0); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !mem_req_o && !rf_we_o && !done_o); // R9
    AST_ILLEGAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> !illegal_o && !mem_req_o); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !mem_req_o && !rf_we_o); // R13
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o && !rf_we_o); // R13
endmodule

bind regblk_xfer regblk_xfer_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_long_o  (mem_long_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .rf_we_o     (rf_we_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o)
);

// File: tb/regblk_xfer_bench.sv
`timescale 1ns/1ps
module regblk_xfer_bench;
    localparam bit EXT = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, load_i = 1'b0, long_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [15:0] mask_i = 16'h0;
    logic [31:0] ea_i = 32'h0;
    logic [2:0]  base_i = 3'd0;
    logic        mem_req, mem_we, mem_long, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, done_o, illegal_o;

    always #2.5 clk = ~clk;

    regblk_xfer #(.AW(32), .EXT_CPU(EXT), .REDUCED_ISA(1'b0)) u_regblk_xfer (
        .clk(clk), .rst(rst), .start_i(start_i), .load_i(load_i), .long_i(long_i),
        .mode_i(mode_i), .mask_i(mask_i), .ea_i(ea_i), .base_i(base_i),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_long_o(mem_long),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
        .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    // Behavioural register file and memory
    bit [31:0] rf [16];
    bit [31:0] memw [bit [31:0]];
    longint    cyc = 0;

    function automatic bit [31:0] mem_rd(bit [31:0] a);
        if (memw.exists(a)) return memw[a];
        return {~a[15:0], a[15:0] ^ {a[1], 15'h1c31}};
    endfunction

    assign rf_rdata = rf[rf_raddr];
    always @* mem_rdata = mem_rd(mem_addr);

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < 8; i++) rf[i] = 32'h8000_1357 ^ (i * 32'h1111_0421);
            for (int i = 0; i < 8; i++) rf[8+i] = 32'h0000_0400 + i * 32'h40;
        end else begin
            if (mem_req && mem_ack && mem_we)
                memw[mem_addr] = mem_long ? mem_wdata : {16'h0, mem_wdata[15:0]};
            if (rf_we) rf[rf_waddr] = rf_wdata;
        end
    end

    typedef struct { bit we; bit [31:0] addr; bit [31:0] data; bit lng; } mx_t;
    typedef struct { bit [3:0] a; bit [31:0] d; } rx_t;
    mx_t    mq[$];
    rx_t    rq[$];
    int     total = 0, bad = 0;
    string  cur_tag;
    bit     exp_bad, fin_seen, out_busy;
    int     wait_left, wpat;
    longint start_cyc, last_evt;
    bit [31:0] h_addr, h_wdata;
    bit        h_we, h_long;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Expected trace from the requirements and the model state at start
    task automatic plan(bit ld, bit lng, bit [1:0] md, bit [15:0] mk, bit [31:0] ea, bit [2:0] bs);
        bit [31:0] st, a, d, v;
        bit [31:0] lb [16];
        int cnt, k;
        st = lng ? 32'd4 : 32'd2;
        a = ea; cnt = $countones(mk); k = 0;
        mq.delete(); rq.delete();
        exp_bad = !ld && md == 2'd1;
        if (exp_bad || mk == 16'h0) return;
        if (ld) begin
            for (int i = 0; i < 16; i++) if (mk[i]) begin
                d = mem_rd(a);
                mq.push_back('{1'b0, a, 32'h0, lng});
                lb[i] = lng ? d : {{16{d[15]}}, d[15:0]};
                a += st;
            end
            for (int i = 0; i < 16; i++) if (mk[i]) rq.push_back('{4'(i), lb[i]});
            if (md == 2'd1) rq.push_back('{{1'b1, bs}, a});
        end else if (md == 2'd2) begin
            for (int r = 15; r >= 0; r--) if (mk[15-r]) begin
                v = rf[r];
                if (EXT && r == 8 + int'(bs)) v = v - st;
                mq.push_back('{1'b1, a, lng ? v : {16'h0, v[15:0]}, lng});
                k++;
                if (k < cnt) a -= st;
            end
            rq.push_back('{{1'b1, bs}, a});
        end else begin
            for (int i = 0; i < 16; i++) if (mk[i]) begin
                v = rf[i];
                mq.push_back('{1'b1, a, lng ? v : {16'h0, v[15:0]}, lng});
                a += st;
            end
        end
    endtask

    // One clock: compare outputs with the expected trace, then drive acknowledge
    task automatic tick();
        mx_t e;
        rx_t f;
        longint ref_evt;
        @(negedge clk);
        if (rst) return;
        if (mem_req) begin
            if (!out_busy) begin
                if (mq.size() == 0) chk(1'b0, cur_tag, "unexpected memory request", mem_addr, 32'h0);
                else begin
                    e = mq.pop_front();
                    chk(mem_we == e.we, cur_tag, "request direction", 32'(mem_we), 32'(e.we));
                    chk(mem_addr == e.addr, cur_tag, "request address", mem_addr, e.addr);
                    chk(mem_long == e.lng, cur_tag, "request size", 32'(mem_long), 32'(e.lng));
                    if (e.we) chk(mem_wdata == e.data, cur_tag, "store data", mem_wdata, e.data);
                end
                h_addr = mem_addr; h_wdata = mem_wdata; h_we = mem_we; h_long = mem_long;
                out_busy = 1'b1;
                wait_left = wpat % 3;
                wpat++;
            end else begin
                chk(mem_addr == h_addr && mem_wdata == h_wdata && mem_we == h_we && mem_long == h_long,
                    "R11", "request held until ack", mem_addr, h_addr);
            end
            if (wait_left == 0) begin
                mem_ack = 1'b1; out_busy = 1'b0; last_evt = cyc;
            end else begin
                mem_ack = 1'b0; wait_left--;
            end
        end else begin
            mem_ack = 1'b0;
            if (out_busy) chk(1'b0, "R11", "request dropped before ack", 32'h0, 32'h1);
            out_busy = 1'b0;
        end
        if (rf_we) begin
            chk(mq.size() == 0, "R6", "register write before all reads", 32'(mq.size()), 32'h0);
            if (rq.size() == 0) chk(1'b0, cur_tag, "unexpected register write", 32'(rf_waddr), 32'h0);
            else begin
                f = rq.pop_front();
                chk(rf_waddr == f.a, cur_tag, "register index", 32'(rf_waddr), 32'(f.a));
                chk(rf_wdata == f.d, cur_tag, "register value", rf_wdata, f.d);
            end
            last_evt = cyc;
        end
        if (done_o || illegal_o) begin
            ref_evt = (last_evt > start_cyc) ? last_evt : start_cyc;
            if (illegal_o) begin
                chk(exp_bad, "R9", "illegal flag", 32'h1, 32'(exp_bad));
                chk(cyc == start_cyc + 1, "R9", "illegal timing", 32'(cyc - start_cyc), 32'h1);
            end else begin
                chk(!exp_bad, "R9", "done on illegal start", 32'h1, 32'h0);
                chk(cyc == ref_evt + 1, "R13", "done timing", 32'(cyc - ref_evt), 32'h1);
            end
            fin_seen = 1'b1;
        end
    endtask

    task automatic run_op(string tag, bit ld, bit lng, bit [1:0] md, bit [15:0] mk,
                          bit [31:0] ea, bit [2:0] bs, bit poke);
        int n;
        cur_tag = tag;
        plan(ld, lng, md, mk, ea, bs);
        fin_seen = 1'b0;
        load_i = ld; long_i = lng; mode_i = md; mask_i = mk; ea_i = ea; base_i = bs;
        start_i = 1'b1; start_cyc = cyc;
        tick();
        start_i = 1'b0;
        n = 0;
        while (!fin_seen && n < 300) begin
            if (poke && n == 2) begin
                start_i = 1'b1; load_i = 1'b0; mode_i = 2'd1; mask_i = 16'hFFFF;
            end else start_i = 1'b0;
            tick();
            n++;
        end
        start_i = 1'b0;
        chk(fin_seen, tag, "operation finished", 32'(fin_seen), 32'h1);
        chk(mq.size() == 0 && rq.size() == 0, tag, "all expected actions seen",
            32'(mq.size() + rq.size()), 32'h0);
        tick();
        chk(!done_o && !illegal_o && !mem_req && !rf_we, "R13", "idle after finish",
            {28'h0, done_o, illegal_o, mem_req, rf_we}, 32'h0);
    endtask

    initial begin
        #1_000_000;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        tick();
        chk(!mem_req && !rf_we && !done_o && !illegal_o, "R1", "idle after reset",
            {28'h0, mem_req, rf_we, done_o, illegal_o}, 32'h0);
        tick();
        chk(!mem_req && !rf_we && !done_o && !illegal_o, "R1", "still idle without start",
            {28'h0, mem_req, rf_we, done_o, illegal_o}, 32'h0);

        run_op("R2 R3 long store",          1'b0, 1'b1, 2'd0, 16'h8181, 32'h200, 3'd0, 1'b0);
        run_op("R2 R8 word store disp",     1'b0, 1'b0, 2'd3, 16'h00F0, 32'h300, 3'd0, 1'b0);
        run_op("R6 R7 long load postinc",   1'b1, 1'b1, 2'd1, 16'h0F03, 32'h100, 3'd2, 1'b0);
        run_op("R8 R7 word load postinc",   1'b1, 1'b0, 2'd1, 16'h0806, 32'h8000, 3'd3, 1'b0);
        run_op("R4 R5 long predec store",   1'b0, 1'b1, 2'd2, 16'hC001, rf[15] - 32'd4, 3'd7, 1'b0);
        run_op("R4 R5 R8 word predec store",1'b0, 1'b0, 2'd2, 16'h0041, rf[9] - 32'd2, 3'd1, 1'b0);
        run_op("R10 empty list",            1'b1, 1'b1, 2'd1, 16'h0000, 32'h500, 3'd4, 1'b0);
        run_op("R9 postinc store",          1'b0, 1'b1, 2'd1, 16'h00FF, 32'h540, 3'd5, 1'b0);
        run_op("R9 postinc store empty",    1'b0, 1'b0, 2'd1, 16'h0000, 32'h540, 3'd5, 1'b0);
        run_op("R12 R3 full load",          1'b1, 1'b1, 2'd0, 16'hFFFF, 32'h600, 3'd6, 1'b1);
        run_op("R3 long store disp",        1'b0, 1'b1, 2'd3, 16'h5AA5, 32'h700, 3'd0, 1'b0);
        run_op("R2 R6 word load indirect",  1'b1, 1'b0, 2'd0, 16'h3003, 32'h102, 3'd1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule